// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the digital front end of a 12-bit converter fed over a parallel bus. A host places a word on the data bus, pulls the active-low chip select low, sets a destination-select line, and raises a write strobe. The rising strobe edge either stores the word in a holding register or stores it in a control register. The control register is presented unchanged on an output. Downstream logic uses it for speed, power-down and reference choices.

The converter code is double buffered. A separate active-low load input copies the holding register into the code register that drives the converter. The copy is level-sensitive, so a host can tie load low and every holding write then reaches the converter without a separate update step. A host can also keep load high, stage a new word, and release it at a chosen moment.

Every host-side input is brought into the system clock domain through a synchronizer chain. Write events are found as a low-to-high change of the synchronized strobe.

Top module: `dacbuf_front`

## Requirements
- R1: A synchronous active-high reset sets the holding register, the control register and the code register to 0x000. This makes `code_o` and `ctrl_o` read 0x000, and a later load with no write also yields 0x000.
- R2: A write whose synchronized strobe edge sees chip select low and `dest_i` = 0 stores `data_i` in the holding register. `ctrl_o` keeps its value.
- R3: A write with `dest_i` = 1 stores `data_i` in the control register. `ctrl_o` shows it 3 clock edges after the strobe rises. Neither the holding register nor the code register changes.
- R4: A strobe edge taken while chip select is high changes no register.
- R5: While the synchronized load is low, the code register copies the holding register on every clock edge. A load falling edge reaches `code_o` on the 3rd clock edge after it. While load is high, `code_o` holds its value, even across holding writes.
- R6: With load held low, each holding write appears on `code_o` 4 clock edges after the strobe rises. It is not yet visible on the 3rd edge.
- R7: When load falls in the same cycle as the strobe rises, `code_o` settles on the newly written word, not the previous one.
- R8: All 12 bits pass unaltered, across the full range 0x000 to 0xFFF.
- R9: A strobe that stays high is one write only. A data change while the strobe is high is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe_i | input | 1 | Write strobe; rising edge captures the bus |
| cs_n_i | input | 1 | Active-low chip select |
| dest_i | input | 1 | Destination: 0 holding register, 1 control register |
| load_n_i | input | 1 | Active-low level-sensitive load of the code register |
| data_i | input | 12 | Parallel write data |
| code_o | output | 12 | Code register driving the converter |
| ctrl_o | output | 12 | Control register contents |

## Verification
A holding or control write lands 3 edges after the strobe rises, and a code update follows on the 4th edge when load is low. A load falling edge moves the code on the 3rd edge. The driver counts falling clock edges from each stimulus and enqueues the expected outputs exactly at those points. It also enqueues an item one edge earlier, holding the old values, so an output that moves too early or too late is caught. The monitor samples just after each falling edge and pops and compares every queued item. This happens long before the next rising edge could move the outputs.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
  typedef enum logic {
    DEST_HOLD = 1'b0,
    DEST_CTRL = 1'b1
  } dest_e;
endpackage

// File: rtl/dacbuf_sync.sv
module dacbuf_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= RST_VAL;
          else     chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= RST_VAL;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dacbuf_wrdet.sv
module dacbuf_wrdet
  import dacbuf_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_s,
  input  logic              cs_n_s,
  input  logic              dest_s,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_hold_o,
  output logic              wr_ctrl_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic strobe_prev_q;
  logic edge_hit;
  dest_e dest;

  always_ff @(posedge clk) begin
    if (rst) strobe_prev_q <= 1'b0;
    else     strobe_prev_q <= strobe_s;
  end

  assign edge_hit  = strobe_s & ~strobe_prev_q & ~cs_n_s;
  assign dest      = dest_e'(dest_s);
  assign wr_hold_o = edge_hit && (dest == DEST_HOLD);
  assign wr_ctrl_o = edge_hit && (dest == DEST_CTRL);
  assign wr_data_o = data_i;

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hold_o || wr_ctrl_o) |=> !(wr_hold_o || wr_ctrl_o));

  // R4
  cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |-> !(wr_hold_o || wr_ctrl_o));
endmodule

// File: rtl/dacbuf_regs.sv
module dacbuf_regs #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hold_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_act_i,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      ctrl_q <= '0;
      code_q <= '0;
    end else begin
      if (wr_hold_i)  hold_q <= wr_data_i;
      if (wr_ctrl_i)  ctrl_q <= wr_data_i;
      if (load_act_i) code_q <= hold_q;
    end
  end

  assign code_o = code_q;
  assign ctrl_o = ctrl_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (hold_q == '0) && (ctrl_q == '0) && (code_q == '0));

  // R5
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    load_act_i |=> (code_q == $past(hold_q)));

  // R5
  load_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !load_act_i |=> $stable(code_q));

  // R3
  ctrl_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl_i |=> $stable(hold_q));

  // R2
  hold_isolate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hold_i |=> $stable(ctrl_q));
endmodule

// File: rtl/dacbuf_front.sv
module dacbuf_front #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_strobe_i,
  input  logic              cs_n_i,
  input  logic              dest_i,
  input  logic              load_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int CTL_W = 4;
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1010;

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic strobe_s, cs_n_s, dest_s, load_n_s;
  logic wr_hold, wr_ctrl;
  logic [DATA_W-1:0] wr_data;

  assign ctl_raw = {load_n_i, dest_i, cs_n_i, wr_strobe_i};
  assign {load_n_s, dest_s, cs_n_s, strobe_s} = ctl_s;

  dacbuf_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) sync_i (
    .clk(clk), .rst(rst), .d_i(ctl_raw), .q_o(ctl_s)
  );

  dacbuf_wrdet #(.DATA_W(DATA_W)) wrdet_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_s (strobe_s),
    .cs_n_s   (cs_n_s),
    .dest_s   (dest_s),
    .data_i   (data_i),
    .wr_hold_o(wr_hold),
    .wr_ctrl_o(wr_ctrl),
    .wr_data_o(wr_data)
  );

  dacbuf_regs #(.DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_hold_i (wr_hold),
    .wr_ctrl_i (wr_ctrl),
    .wr_data_i (wr_data),
    .load_act_i(~load_n_s),
    .code_o    (code_o),
    .ctrl_o    (ctrl_o)
  );
endmodule

// File: tb/dacbuf_front_tb.sv
module dacbuf_front_tb_top;
  typedef struct {
    logic [11:0] code;
    logic [11:0] ctrl;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_strobe = 1'b0, cs_n = 1'b1, dest = 1'b0, load_n = 1'b1;
  logic [11:0] data = '0;
  logic [11:0] code, ctrl;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t sb_q[$];
  logic [11:0] m_hold = '0, m_ctrl = '0, m_code = '0;

  always #5 clk = ~clk;

  dacbuf_front dut_i (
    .clk(clk), .rst(rst), .wr_strobe_i(wr_strobe), .cs_n_i(cs_n),
    .dest_i(dest), .load_n_i(load_n), .data_i(data),
    .code_o(code), .ctrl_o(ctrl)
  );

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_now(input string req);
    exp_t e;
    e.code = m_code; e.ctrl = m_ctrl; e.req = req;
    sb_q.push_back(e);
  endtask

  // Monitor: pops and compares shortly after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (code !== e.code || ctrl !== e.ctrl) begin
          n_fail++;
          $display("FAIL %s: code=%h ctrl=%h expected code=%h ctrl=%h",
                   e.req, code, ctrl, e.code, e.ctrl);
        end
      end
    end
  end

  // Bus write: set up cs/dest/data, raise strobe, check due cycles.
  task automatic bus_write(input logic d, input logic [11:0] v,
                           input logic sel, input string req);
    cs_n = ~sel; dest = d; data = v;
    wait_neg(3);
    wr_strobe = 1'b1;
    wait_neg(3);                 // 3 rising edges after strobe rose
    if (sel && d == 1'b0) m_hold = v;
    if (sel && d == 1'b1) m_ctrl = v;
    expect_now(req);             // code still old on edge 3
    wait_neg(1);
    if (!load_n) m_code = m_hold;
    expect_now(req);
    wr_strobe = 1'b0;
    wait_neg(3);
    cs_n = 1'b1;
    wait_neg(3);
  endtask

  task automatic load_pulse(input string req);
    load_n = 1'b0;
    wait_neg(2);
    expect_now(req);             // not yet on edge 2
    wait_neg(1);
    m_code = m_hold;
    expect_now(req);             // copied on edge 3
    load_n = 1'b1;
    wait_neg(3);
  endtask

  initial begin
    wait_neg(3);
    rst = 1'b0;
    wait_neg(1);
    expect_now("R1 reset outputs");
    load_pulse("R1 holding cleared");

    bus_write(1'b0, 12'h5A3, 1'b1, "R2/R5 hold write, load high");
    expect_now("R5 code frozen while load high");
    load_pulse("R5 load copies holding");

    bus_write(1'b1, 12'h3C7, 1'b1, "R3 control write");
    load_pulse("R3 holding untouched by control write");

    bus_write(1'b0, 12'h111, 1'b0, "R4 cs high ignored");
    bus_write(1'b1, 12'h222, 1'b0, "R4 cs high ctrl ignored");
    load_pulse("R4 holding unchanged after deselected write");

    // Load tied low: writes follow directly.
    load_n = 1'b0;
    wait_neg(4);
    bus_write(1'b0, 12'hFFF, 1'b1, "R6/R8 follow max code");
    bus_write(1'b0, 12'h000, 1'b1, "R6/R8 follow min code");
    bus_write(1'b0, 12'hA5C, 1'b1, "R6 follow mid code");
    bus_write(1'b1, 12'hFFF, 1'b1, "R8 ctrl full range");
    load_n = 1'b1;
    wait_neg(4);

    // R7: load falls together with the strobe edge.
    cs_n = 1'b0; dest = 1'b0; data = 12'h6E1;
    wait_neg(3);
    wr_strobe = 1'b1; load_n = 1'b0;
    wait_neg(3);
    m_hold = 12'h6E1;
    m_code = 12'hA5C;            // edge 3 copied the old holding value
    expect_now("R7 old value on edge 3");
    wait_neg(1);
    m_code = m_hold;
    expect_now("R7 new value after simultaneous load");
    wr_strobe = 1'b0; load_n = 1'b1;
    wait_neg(3);
    cs_n = 1'b1;
    wait_neg(3);

    // R9: strobe held high, data changes, no second write.
    cs_n = 1'b0; dest = 1'b0; data = 12'h0F0;
    wait_neg(3);
    wr_strobe = 1'b1;
    wait_neg(4);
    m_hold = 12'h0F0;
    data = 12'hF0F;
    wait_neg(6);
    wr_strobe = 1'b0;
    wait_neg(3);
    cs_n = 1'b1;
    load_pulse("R9 level strobe writes once");

    // R1 again: reset from a populated state.
    rst = 1'b1;
    wait_neg(2);
    rst = 1'b0;
    m_hold = '0; m_ctrl = '0; m_code = '0;
    wait_neg(1);
    expect_now("R1 reset clears populated state");
    load_pulse("R1 holding cleared after reset");

    wait_neg(3);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule